// File: doc/BRIEF.md
# Selectable RTC tick generator

The block turns a fast sub-clock into a slow real-time tick. One binary counter runs on the sub-clock, which is twice the crystal input frequency. A rate select takes the tick from one of two stages of that counter. With a 32768 Hz crystal the sub-clock is 65536 Hz, so the last stage gives 1 Hz and the stage before it gives 2 Hz.

An enable input starts the counter. When the enable is low, the counter is held at zero. Each tick sets a pending flag, and that flag stays set until software clears it. The interrupt request is the pending flag gated by a mask input. Masking hides the request, but the pending flag keeps its value.

Top module: `rtc_tick_gen`

## Requirements
- R1: While rst_ni is low, tick_o, pend_o and irq_o are 0 and the counter is zero.
- R2: With en_i=1 and rate_sel_i=0 (slow), tick_o pulses once every 2^CNT_W sub-clock cycles.
- R3: With en_i=1 and rate_sel_i=1 (fast), tick_o pulses once every 2^(CNT_W-1) sub-clock cycles.
- R4: While en_i=0 the counter is held at zero and tick_o stays 0. After en_i goes high, the first tick_o comes on the clock edge that is the full selected period of enabled edges later.
- R5: tick_o is high for exactly one sub-clock cycle per tick.
- R6: A tick sets pend_o on the same edge on which tick_o rises. pend_o then stays 1 until a cycle with clr_i=1. If a tick and clr_i=1 fall on the same edge, the set wins.
- R7: irq_o equals pend_o AND NOT mask_i (mask_i=1 blocks the request). Masking leaves pend_o unchanged.
- R8: Changing rate_sel_i while the counter runs does not reset the counter. The next tick comes at the next boundary of the newly selected stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sub-clock (twice the crystal frequency) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter run enable; low holds the counter at zero |
| rate_sel_i | input | 1 | 0 = slow tick (full counter), 1 = fast tick (half period) |
| mask_i | input | 1 | 1 blocks the interrupt request |
| clr_i | input | 1 | Clears the pending flag |
| tick_o | output | 1 | One-cycle tick pulse |
| pend_o | output | 1 | Sticky pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
tick_o and pend_o are registered. They change on the first edge at which the sampled inputs reach a stage boundary. irq_o follows mask_i in the same cycle, without any register. The bench drives its inputs on the falling edge and samples all outputs on the next falling edge, so each output is checked one half cycle after the edge that should have changed it. A behavioural model, updated on the same rising edge, supplies the expected values. Directed measurements count the rising edges from a stimulus to the first tick: after an enable, after a rate change partway through a period, and with a clear held during a tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // wrap_o[k]: stage k about to roll over on the next enabled edge
  for (genvar k = 0; k < CNT_W; k++) begin : g_wrap
    assign wrap_o[k] = &cnt_q[k:0];
  end
endmodule

// File: rtl/rtc_tick_sel.sv
module rtc_tick_sel
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  rate_e            rate_i,
  input  logic [CNT_W-1:0] wrap_i,
  output logic             hit_o,
  output logic             tick_o
);
  localparam int SlowStage = CNT_W - 1;
  localparam int FastStage = CNT_W - 2;

  logic tick_q;

  always_comb begin
    unique case (rate_i)
      RATE_FAST: hit_o = en_i & wrap_i[FastStage];
      default:   hit_o = en_i & wrap_i[SlowStage];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= hit_o;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/rtc_pend.sv
module rtc_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  // set has priority so a tick coincident with a clear is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & ~mask_i;
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rate_sel_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic tick_o,
  output logic pend_o,
  output logic irq_o
);
  logic [CNT_W-1:0] wrap;
  logic             hit;
  rate_e            rate;

  assign rate = rate_e'(rate_sel_i);

  rtc_divider #(.CNT_W(CNT_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .wrap_o (wrap)
  );

  rtc_tick_sel #(.CNT_W(CNT_W)) i_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .rate_i (rate),
    .wrap_i (wrap),
    .hit_o  (hit),
    .tick_o (tick_o)
  );

  rtc_pend i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr_i),
    .mask_i (mask_i),
    .pend_o (pend_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/rtc_tick_gen_chk.sv
module rtc_tick_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic mask_i,
  input logic clr_i,
  input logic tick_o,
  input logic pend_o,
  input logic irq_o
);
  p_no_tick_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);

  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  p_tick_sets_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> pend_o);

  p_pend_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);

  p_clear_works_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!pend_o || tick_o));

  p_irq_needs_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_o && !mask_i));

  p_mask_keeps_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i && mask_i) |=> pend_o);
endmodule

bind rtc_tick_gen rtc_tick_gen_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .mask_i (mask_i),
  .clr_i  (clr_i),
  .tick_o (tick_o),
  .pend_o (pend_o),
  .irq_o  (irq_o)
);

// File: tb/test_rtc_tick_gen.sv
module test_rtc_tick_gen;
  localparam int CNT_W = 6;
  localparam int FULL  = 1 << CNT_W;
  localparam int HALF  = 1 << (CNT_W - 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, rate_sel_i = 1'b0, mask_i = 1'b0, clr_i = 1'b0;
  logic tick_o, pend_o, irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int  m_cnt;
  bit  m_tick, m_pend, fire;

  always #2 clk = ~clk;

  rtc_tick_gen #(.CNT_W(CNT_W)) i_rtc_tick_gen (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .rate_sel_i(rate_sel_i),
    .mask_i(mask_i), .clr_i(clr_i), .tick_o(tick_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_tick = 0; m_pend = 0;
    end else begin
      fire   = en_i && (((m_cnt + 1) % (rate_sel_i ? HALF : FULL)) == 0);
      m_tick = fire;
      m_pend = fire || (m_pend && !clr_i);
      m_cnt  = en_i ? (m_cnt + 1) % FULL : 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(tick_o == m_tick, "R2/R3 tick_o", tick_o, m_tick);
      chk(pend_o == m_pend, "R6 pend_o", pend_o, m_pend);
      chk(irq_o == (m_pend && !mask_i), "R7 irq_o", irq_o, m_pend && !mask_i);
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin step(); n++; end while (!tick_o && n < 4 * FULL);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!tick_o && !pend_o && !irq_o, "R1 reset outputs", {tick_o, pend_o, irq_o}, 0);
    rst_ni = 1'b1;
    repeat (5) step();
    chk(!tick_o, "R4 idle no tick", tick_o, 0);

    en_i = 1'b1; rate_sel_i = 1'b1;
    measure(n); chk(n == HALF, "R4 first tick after enable", n, HALF);
    measure(n); chk(n == HALF, "R3 fast period", n, HALF);
    step(); chk(!tick_o, "R5 one-cycle pulse", tick_o, 0);
    repeat (7) step();
    rate_sel_i = 1'b0;
    measure(n); chk(n == FULL - 8, "R8 rate change keeps phase", n, FULL - 8);
    measure(n); chk(n == FULL, "R2 slow period", n, FULL);

    mask_i = 1'b1; step();
    chk(pend_o && !irq_o, "R7 mask hides irq", {pend_o, irq_o}, 2);
    mask_i = 1'b0; step();
    chk(irq_o, "R7 unmask restores irq", irq_o, 1);
    clr_i = 1'b1; step(); clr_i = 1'b0;
    chk(!pend_o && !irq_o, "R6 clear", {pend_o, irq_o}, 0);

    en_i = 1'b0; repeat (5) step();
    chk(!tick_o, "R4 stopped", tick_o, 0);
    en_i = 1'b1;
    measure(n); chk(n == FULL, "R4 restart full period", n, FULL);

    rate_sel_i = 1'b1; clr_i = 1'b1;
    measure(n); chk(n == HALF, "R3 fast after switch", n, HALF);
    chk(pend_o, "R6 set beats clear", pend_o, 1);
    step(); chk(!pend_o, "R6 held clear", pend_o, 0);
    clr_i = 1'b0;
    repeat (3) step();
    finish_up();
  end
endmodule